// File: doc/BRIEF.md
# Serial Command and Status Port

This block is the serial slave front end of a sector-based record and playback controller. A host lowers chip select and clocks in a 20-bit command frame: a 5-bit opcode followed by a 15-bit sector address. During the same frame the block clocks out a 20-bit word. That word is the device status word, or an identification word when the frame just before was an identification request. When a complete frame ends, the opcode is decoded into a one-cycle command strobe. The strobe carries the opcode and the captured address to the execution logic, which lies outside this block.

The port holds three sticky event flags: overflow, end-of-data and illegal address. Each flag reaches the host in the next word shifted out. A flag is cleared only when a complete frame that carried it ends. Events that arrive during a frame are kept for the frame after. The serial pins are brought into the system clock domain through synchronizers, so the serial clock must be several system clocks slower than the system clock.

Top module: `spi_cmd_port`

## Requirements
- R1: While spi_cs_n is low, spi_mosi is sampled on each rising spi_sclk edge. The k-th sampled bit is frame bit k. Bits 0-4 form the opcode (bit 0 is the LSB) and bits 5-19 form the sector address (bit 5 is the LSB).
- R2: The outgoing word is sent LSB first. Bit 0 is driven on spi_miso once spi_cs_n is low, before the first rising edge. The word advances one bit on each falling spi_sclk edge, and positions beyond bit 19 read 0.
- R3: While spi_cs_n is high, spi_miso_oe and spi_miso are 0, and spi_sclk and spi_mosi activity has no effect.
- R4: Status word layout: bit 0 overflow, bit 1 end-of-data, bit 2 illegal address, bit 3 low_batt, bit 4 zero, bits 5-19 cur_sector. The flags are taken when spi_cs_n falls.
- R5: Identification word layout: bits 0-3 are the same as in the status word, bits 4-8 hold FAMILY_CODE (default 5) and bits 9-12 hold DEVICE_CODE (default 3). Bits 13-19 carry no meaning.
- R6: The identification word is sent in the frame that follows a complete frame whose opcode decoded to the identify code 1. Every other frame sends the status word.
- R7: The 20th rising edge ends the frame, and cmd_valid then pulses for one cycle with cmd_op and cmd_addr. Codes: 0 no-op, 1 identify, 2 power up, 3 halt, 4 halt and sleep, 5 record at address, 6 record next, 7 play at address, 8 play next, 9 seek at address, 10 seek next, 11 erase, 12 data write, 13 data read. Codes 14-31 are reported as 0.
- R8: If spi_cs_n rises before 20 bits have arrived, the frame is discarded. It gives no strobe, clears no flag, and leaves the R6 selection unchanged.
- R9: A one-cycle pulse on ev_overflow or ev_end_of_data sets the matching flag. The flag stays set until a complete frame that reported it as 1 ends.
- R10: An event that arrives during a frame is not in that frame's word and is not cleared at its end. It is reported in the next frame.
- R11: Codes 5, 7, 9, 11, 12 and 13 with an address of NUM_SECTORS (1280) or more set the illegal address flag when the frame ends and give no strobe. Addresses carried by the other codes are not range-checked.
- R12: Bits after the 20th in the same chip-select period are ignored. They produce no second strobe and do not change the captured command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for spi_miso pad |
| ev_overflow | input | 1 | Pulse: record ran past end of memory |
| ev_end_of_data | input | 1 | Pulse: play or seek stopped on a stored end marker |
| low_batt | input | 1 | Supply-low level |
| cur_sector | input | 15 | Current or last active sector |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 5 | Decoded opcode |
| cmd_addr | output | 15 | Captured sector address |

## Verification
All 32 opcode values are sent, each with a different sector and supply input. This separates the decode table, the fold of undefined codes to no-op, and the field positions of the status word. Each addressed opcode is swept across the 1280 boundary and to the largest address, and the same high addresses are sent with unaddressed codes. This tells a range check applied to the right opcodes apart from one applied to all of them. Flag events are injected between frames, in the middle of a frame and just before the last bit. These cases show the difference between sticky flags, clearing on a report, and event hold-over. Short, long and deselected clocking show that partial frames are dropped, that extra bits are ignored, and that the identification selection survives a dropped frame.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int OPC_W   = 5;
  localparam int NUM_OPS = 14;
  localparam int FLAG_W  = 3;
  localparam int FLG_OVF = 0;
  localparam int FLG_EOD = 1;
  localparam int FLG_ILL = 2;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP        = 5'd0,
    OP_ID         = 5'd1,
    OP_POWER_UP   = 5'd2,
    OP_HALT       = 5'd3,
    OP_HALT_SLEEP = 5'd4,
    OP_REC_AT     = 5'd5,
    OP_REC_NEXT   = 5'd6,
    OP_PLAY_AT    = 5'd7,
    OP_PLAY_NEXT  = 5'd8,
    OP_SEEK_AT    = 5'd9,
    OP_SEEK_NEXT  = 5'd10,
    OP_ERASE      = 5'd11,
    OP_DATA_WR    = 5'd12,
    OP_DATA_RD    = 5'd13
  } opcode_e;

  // Undefined codes fold onto the no-op.
  function automatic opcode_e op_decode(input logic [OPC_W-1:0] raw);
    opcode_e r;
    if (raw < OPC_W'(NUM_OPS)) r = opcode_e'(raw);
    else                       r = OP_NOP;
    return r;
  endfunction

  // Opcodes whose address field names a sector and is range-checked.
  function automatic logic op_addressed(input opcode_e op);
    logic r;
    case (op)
      OP_REC_AT, OP_PLAY_AT, OP_SEEK_AT,
      OP_ERASE, OP_DATA_WR, OP_DATA_RD: r = 1'b1;
      default:                          r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int             N       = 1,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], din[g]};
    end

    assign dout[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/scp_rx.sv
module scp_rx
  import scp_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int NUM_SECTORS = 1280
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_active,
  input  logic              sclk_rise,
  input  logic              mosi,
  output logic              frame_done,
  output logic              addr_bad,
  output logic              id_next,
  output logic              cmd_valid,
  output logic [OPC_W-1:0]  cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);

  localparam int FRAME_W = OPC_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL   = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0]  CNT_LAST   = CNT_W'(FRAME_W - 1);
  localparam logic [ADDR_W:0]   ADDR_LIMIT = (ADDR_W + 1)'(NUM_SECTORS);

  logic [FRAME_W-1:0] frm_q, frm_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               done_q, done_d;
  logic               id_q, id_d;
  logic               vld_q, vld_d;
  opcode_e            op_q, op_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;

  logic               take;
  opcode_e            dec_op;
  logic [ADDR_W-1:0]  dec_addr;
  logic               dec_bad;

  // Decode of the completed frame, valid in the cycle done_q is high.
  always_comb begin
    dec_op   = op_decode(frm_q[OPC_W-1:0]);
    dec_addr = frm_q[FRAME_W-1:OPC_W];
    dec_bad  = op_addressed(dec_op) && ({1'b0, dec_addr} >= ADDR_LIMIT);
  end

  always_comb begin
    take   = sel_active && sclk_rise && (cnt_q != CNT_FULL);
    frm_d  = frm_q;
    if (take) frm_d[cnt_q] = mosi;
    if (!sel_active)  cnt_d = '0;
    else if (take)    cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
    done_d = take && (cnt_q == CNT_LAST);
    vld_d  = done_q && !dec_bad;
    op_d   = done_q ? dec_op   : op_q;
    addr_d = done_q ? dec_addr : addr_q;
    id_d   = done_q ? (dec_op == OP_ID) : id_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      id_q   <= 1'b0;
      vld_q  <= 1'b0;
      op_q   <= OP_NOP;
      addr_q <= '0;
    end else begin
      frm_q  <= frm_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      id_q   <= id_d;
      vld_q  <= vld_d;
      op_q   <= op_d;
      addr_q <= addr_d;
    end
  end

  assign frame_done = done_q;
  assign addr_bad   = done_q && dec_bad;
  assign id_next    = id_q;
  assign cmd_valid  = vld_q;
  assign cmd_op     = op_q;
  assign cmd_addr   = addr_q;

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) vld_q |=> !vld_q);  // R7
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !sel_active |=> (cnt_q == '0));  // R3
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CNT_FULL);  // R12
  AST_BAD_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n) (done_q && dec_bad) |=> !vld_q);  // R11
  AST_DESEL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) !sel_active |=> !done_q);  // R8

endmodule

// File: rtl/scp_flags.sv
module scp_flags
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] evt,
  input  logic              snap,
  input  logic              clear,
  output logic [FLAG_W-1:0] flags
);

  logic [FLAG_W-1:0] flg_q, flg_d;
  logic [FLAG_W-1:0] rep_q, rep_d;

  // Only the flags that went out in this frame are cleared; new events win.
  always_comb begin
    rep_d = snap ? flg_q : rep_q;
    flg_d = (flg_q & ~(clear ? rep_q : '0)) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      rep_q <= '0;
    end else begin
      flg_q <= flg_d;
      rep_q <= rep_d;
    end
  end

  assign flags = flg_q;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n) evt[FLG_OVF] |=> flg_q[FLG_OVF]);  // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flg_q[FLG_EOD] && !clear) |=> flg_q[FLG_EOD]);  // R9
  AST_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n) (!flg_q[FLG_OVF] && !evt[FLG_OVF]) |=> !flg_q[FLG_OVF]);  // R9
  AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (clear && evt[FLG_EOD]) |=> flg_q[FLG_EOD]);  // R10
  AST_ILL_SETS: assert property (@(posedge clk) disable iff (!rst_n) evt[FLG_ILL] |=> flg_q[FLG_ILL]);  // R11

endmodule

// File: rtl/scp_tx.sv
module scp_tx
  import scp_pkg::*;
#(
  parameter int         ADDR_W      = 15,
  parameter logic [4:0] FAMILY_CODE = 5'h05,
  parameter logic [3:0] DEVICE_CODE = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_active,
  input  logic              cs_fall,
  input  logic              sclk_fall,
  input  logic [FLAG_W-1:0] flags,
  input  logic              low_batt,
  input  logic [ADDR_W-1:0] sector,
  input  logic              id_sel,
  output logic              miso,
  output logic              miso_oe
);

  localparam int WORD_W      = FLAG_W + 2 + ADDR_W;
  localparam int ID_FAM_LSB  = FLAG_W + 1;
  localparam int ID_DEV_LSB  = ID_FAM_LSB + 5;

  logic [WORD_W-1:0] status_w, id_w;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;

  always_comb begin
    status_w = {sector, 1'b0, low_batt, flags};
    id_w = '0;
    id_w[FLAG_W:0]            = {low_batt, flags};
    id_w[ID_FAM_LSB +: 5]     = FAMILY_CODE;
    id_w[ID_DEV_LSB +: 4]     = DEVICE_CODE;
  end

  always_comb begin
    if (cs_fall)                      sh_d = id_sel ? id_w : status_w;
    else if (sel_active && sclk_fall) sh_d = sh_q >> 1;
    else                              sh_d = sh_q;
    oe_d = sel_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      oe_q <= oe_d;
    end
  end

  assign miso    = oe_q & sh_q[0];
  assign miso_oe = oe_q;

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !sel_active |=> !miso_oe);  // R3
  AST_SHIFT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (sel_active && !sclk_fall && !cs_fall) |=> $stable(sh_q));  // R2
  AST_LOAD_BIT0: assert property (@(posedge clk) disable iff (!rst_n) cs_fall |=> (miso == $past(flags[FLG_OVF])));  // R4

endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
  import scp_pkg::*;
#(
  parameter int         ADDR_W      = 15,
  parameter int         NUM_SECTORS = 1280,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] FAMILY_CODE = 5'h05,
  parameter logic [3:0] DEVICE_CODE = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              ev_overflow,
  input  logic              ev_end_of_data,
  input  logic              low_batt,
  input  logic [ADDR_W-1:0] cur_sector,
  output logic              cmd_valid,
  output logic [OPC_W-1:0]  cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);

  logic [2:0] pin_s;
  logic       sclk_prev_q, cs_prev_q;
  logic       sel_active, sclk_rise, sclk_fall, cs_fall;
  logic       frame_done, addr_bad, id_next;
  logic [FLAG_W-1:0] flags;

  scp_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_mosi, spi_sclk, spi_cs_n}),
    .dout (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= pin_s[1];
      cs_prev_q   <= pin_s[0];
    end
  end

  always_comb begin
    sel_active = !pin_s[0];
    sclk_rise  = pin_s[1] && !sclk_prev_q;
    sclk_fall  = !pin_s[1] && sclk_prev_q;
    cs_fall    = !pin_s[0] && cs_prev_q;
  end

  scp_rx #(.ADDR_W(ADDR_W), .NUM_SECTORS(NUM_SECTORS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_active(sel_active),
    .sclk_rise (sclk_rise),
    .mosi      (pin_s[2]),
    .frame_done(frame_done),
    .addr_bad  (addr_bad),
    .id_next   (id_next),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr)
  );

  scp_flags u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  ({addr_bad, ev_end_of_data, ev_overflow}),
    .snap (cs_fall),
    .clear(frame_done),
    .flags(flags)
  );

  scp_tx #(.ADDR_W(ADDR_W), .FAMILY_CODE(FAMILY_CODE), .DEVICE_CODE(DEVICE_CODE)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_active(sel_active),
    .cs_fall   (cs_fall),
    .sclk_fall (sclk_fall),
    .flags     (flags),
    .low_batt  (low_batt),
    .sector    (cur_sector),
    .id_sel    (id_next),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe)
  );

endmodule

// File: tb/spi_cmd_port_tb_top.sv
module spi_cmd_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso, spi_miso_oe;
  logic        ev_overflow, ev_end_of_data, low_batt;
  logic [14:0] cur_sector;
  logic        cmd_valid;
  logic [4:0]  cmd_op;
  logic [14:0] cmd_addr;

  always #4 clk = ~clk;

  spi_cmd_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .ev_overflow(ev_overflow), .ev_end_of_data(ev_end_of_data),
    .low_batt(low_batt), .cur_sector(cur_sector),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  int checks = 0;
  int fails  = 0;
  int n_cmd  = 0;
  bit done   = 0;
  logic [4:0]  mon_op;
  logic [14:0] mon_addr;

  // Bench model of the flags and the word selection
  logic m_ovf = 0, m_eod = 0, m_ill = 0, m_sid = 0, m_lb = 0;
  logic [14:0] m_sec = '0;

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      n_cmd++;
      mon_op   = cmd_op;
      mon_addr = cmd_addr;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit bhas(input int op);
    return (op == 5) || (op == 7) || (op == 9) || (op == 11) || (op == 12) || (op == 13);
  endfunction

  task automatic set_inputs(input logic [14:0] sec, input logic lb);
    @(negedge clk);
    m_sec = sec; m_lb = lb;
    cur_sector = sec; low_batt = lb;
  endtask

  task automatic pulse(input logic eo, input logic ee);
    @(negedge clk);
    ev_overflow = eo; ev_end_of_data = ee;
    @(negedge clk);
    ev_overflow = 0; ev_end_of_data = 0;
    if (eo) m_ovf = 1;
    if (ee) m_eod = 1;
  endtask

  task automatic run_frame(input logic [23:0] bits, input int nbits, input int evt_at,
                           input logic eo, input logic ee, output logic [23:0] got);
    got = '0;
    @(negedge clk); spi_cs_n = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = bits[i];
      if (i == evt_at) begin
        ev_overflow = eo; ev_end_of_data = ee;
        @(negedge clk);
        ev_overflow = 0; ev_end_of_data = 0;
        if (eo) m_ovf = 1;
        if (ee) m_eod = 1;
      end
      repeat (4) @(negedge clk);
      got[i] = spi_miso;
      spi_sclk = 1;
      repeat (8) @(negedge clk);
      spi_sclk = 0;
      repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    spi_cs_n = 1;
    repeat (16) @(negedge clk);
  endtask

  task automatic do_cmd(input logic [4:0] op, input logic [14:0] addr, input int nbits,
                        input int evt_at, input logic eo, input logic ee);
    logic [23:0] exp_w, got, mask, bits;
    logic [2:0]  snap;
    int nb, dop;
    bit bad, was_id;
    snap   = {m_ill, m_eod, m_ovf};
    was_id = m_sid;
    if (m_sid) begin
      exp_w = '0;
      exp_w[3:0]  = {m_lb, snap};
      exp_w[8:4]  = 5'h05;
      exp_w[12:9] = 4'h3;
      mask = 24'h001FFF;
    end else begin
      exp_w = {4'b0, m_sec, 1'b0, m_lb, snap};
      mask = 24'hFFFFFF;
    end
    if (nbits < 24) mask = mask & ((24'h1 << nbits) - 24'h1);
    bits = {4'b1011, addr, op};
    nb = n_cmd;
    run_frame(bits, nbits, evt_at, eo, ee, got);
    if (was_id) chk("R5 R6 id word", int'(got & mask), int'(exp_w & mask));
    else        chk("R2 R4 status word", int'(got & mask), int'(exp_w & mask));
    if (nbits >= 20) begin
      dop = (op < 5'd14) ? int'(op) : 0;
      bad = bhas(dop) && (addr >= 15'd1280);
      m_ovf = m_ovf & ~snap[0];
      m_eod = m_eod & ~snap[1];
      m_ill = (m_ill & ~snap[2]) | bad;
      m_sid = (dop == 1);
      if (bad) chk("R11 no strobe", n_cmd - nb, 0);
      else chk("R1 R7 R12 strobe", ((n_cmd - nb) << 20) | (int'(mon_op) << 15) | int'(mon_addr),
               (1 << 20) | (dop << 15) | int'(addr));
    end else begin
      chk("R8 short frame", n_cmd - nb, 0);
    end
  endtask

  task automatic idle_toggle();
    int nb;
    nb = n_cmd;
    @(negedge clk);
    for (int i = 0; i < 25; i++) begin
      spi_mosi = i[0];
      spi_sclk = 1;
      repeat (4) @(negedge clk);
      if (i == 12) chk("R3 idle pins", {spi_miso_oe, spi_miso}, 0);
      spi_sclk = 0;
      repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chk("R3 no strobe", n_cmd - nb, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; spi_cs_n = 1; spi_sclk = 0; spi_mosi = 0;
    ev_overflow = 0; ev_end_of_data = 0; low_batt = 0; cur_sector = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R3 reset state", {spi_miso_oe, spi_miso, cmd_valid}, 0);

    // Every opcode value, varying sector and supply inputs
    for (int op = 0; op < 32; op++) begin
      set_inputs(15'((op * 1237 + 91) & 32767), op[1]);
      do_cmd(5'(op), 15'(op * 37 + 5), 20, -1, 0, 0);
    end

    // Identify twice in a row, then back to status
    do_cmd(5'd1, 15'd9, 20, -1, 0, 0);
    do_cmd(5'd1, 15'd9, 20, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);

    // Identify, dropped frame, selection must persist
    do_cmd(5'd1, 15'd0, 20, -1, 0, 0);
    do_cmd(5'd3, 15'd0, 11, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);

    // Address range around the sector count
    for (int k = 0; k < 6; k++) begin
      for (int a = 1276; a < 1284; a++) begin
        do_cmd(5'(k == 0 ? 5 : k == 1 ? 7 : k == 2 ? 9 : k + 8), 15'(a), 20, -1, 0, 0);
      end
      do_cmd(5'(k == 0 ? 5 : k == 1 ? 7 : k == 2 ? 9 : k + 8), 15'h7FFF, 20, -1, 0, 0);
    end
    do_cmd(5'd3, 15'h7FFF, 20, -1, 0, 0);
    do_cmd(5'd6, 15'd1500, 20, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);

    // Flag events between frames
    pulse(1, 0); do_cmd(5'd0, 15'd0, 20, -1, 0, 0); do_cmd(5'd0, 15'd0, 20, -1, 0, 0);
    pulse(0, 1); do_cmd(5'd0, 15'd0, 20, -1, 0, 0); do_cmd(5'd0, 15'd0, 20, -1, 0, 0);
    pulse(1, 1); do_cmd(5'd2, 15'd8, 20, -1, 0, 0); do_cmd(5'd0, 15'd0, 20, -1, 0, 0);

    // Events inside a frame carried to the next (R10)
    do_cmd(5'd0, 15'd0, 20, 10, 1, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, 19, 0, 1);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);

    // Short frames clear nothing (R8)
    pulse(1, 0);
    do_cmd(5'd8, 15'd100, 7, -1, 0, 0);
    do_cmd(5'd8, 15'd100, 19, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);

    // Illegal address reported in the following frame
    do_cmd(5'd5, 15'd2000, 20, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);
    do_cmd(5'd0, 15'd0, 20, -1, 0, 0);

    // Long frame: extra bits ignored, output zero past the word (R12)
    set_inputs(15'h5555, 1);
    do_cmd(5'd7, 15'd300, 24, -1, 0, 0);

    // Deselected clocking (R3), then a normal frame
    idle_toggle();
    do_cmd(5'd2, 15'd5, 20, -1, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule